// File: doc/BRIEF.md
# Signed/Unsigned Multiply-Accumulate Datapath

This block multiplies two 16-bit operands and folds the product into a 35-bit running accumulator. Each operand has its own input register, loaded by its own strobe. A four-bit mode word is loaded whenever either operand strobe fires. The mode word holds four bits: format (signed or unsigned), round, accumulate and subtract. The 32-bit product can be rounded by adding 2^15. It is then widened to 35 bits by sign or zero extension, according to the format bit.

A separate product strobe commits the new accumulator value. That value is one of three things: the widened product alone, the product plus the old accumulator, or the product minus the old accumulator. When a preload strobe comes with the product strobe, a 35-bit external word is written into the accumulator instead of the arithmetic result.

The block drives out the committed accumulator. It also drives out the arithmetic next-state value, which a downstream output or preload stage can pick up. All strobes are single-cycle enables on one clock. The reset is synchronous and active high.

Top module: `mac_unit`

## Requirements
- R1: `x_in` is loaded into the X operand register only on a cycle with `x_stb` high, and `y_in` into the Y operand register only on a cycle with `y_stb` high. Operand input changes without the matching strobe have no effect on `acc_next`.
- R2: The mode bits `tc_in`, `rnd_in`, `acc_in` and `sub_in` are loaded on any cycle where `x_stb` or `y_stb` is high, and are held otherwise.
- R3: With the registered format bit high, both operands are two's complement and the product is sign-extended to 35 bits. With it low, both are unsigned and the product is zero-extended.
- R4: With the registered round bit high, 0x8000 (a one at bit 15) is added to the product. With it low, the product is unchanged.
- R5: With the registered accumulate bit low, a product strobe writes the widened product into the accumulator.
- R6: With accumulate high and subtract low, a product strobe writes product plus old accumulator.
- R7: With accumulate high and subtract high, a product strobe writes product minus old accumulator.
- R8: `acc_q` changes only on cycles with `p_stb` high. `acc_next` always shows the arithmetic result for the current registered operands, mode and accumulator.
- R9: When `pre_ld` and `p_stb` are both high, `pre_data` is written into the accumulator, whatever the mode bits are.
- R10: Accumulator arithmetic wraps modulo 2^35, and no overflow is reported.
- R11: Synchronous reset clears the operand, mode and accumulator registers, so `acc_q` and `acc_next` both read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| x_in | input | 16 | X operand |
| y_in | input | 16 | Y operand |
| x_stb | input | 1 | Load X register (and mode word) |
| y_stb | input | 1 | Load Y register (and mode word) |
| tc_in | input | 1 | Format: 1 two's complement, 0 unsigned |
| rnd_in | input | 1 | Round at bit 15 |
| acc_in | input | 1 | Accumulate (1) or load (0) |
| sub_in | input | 1 | Subtract: product minus accumulator |
| p_stb | input | 1 | Commit the accumulator |
| pre_ld | input | 1 | Preload select, qualified by p_stb |
| pre_data | input | 35 | Preload value |
| acc_q | output | 35 | Committed accumulator |
| acc_next | output | 35 | Arithmetic next-state value |

## Verification
The hardest situation to reach is a wrap past 2^35. From the ports it needs an accumulator already near the top of the range before a product is added. The stimulus gets there with a preload of all ones, followed by an add of a product of one, which must give zero.

Extreme signed products and unsigned maximums with rounding are driven as directed cases. Random cycles then mix independent operand, mode, commit and preload strobes. This covers a mode word captured by only one strobe, and a commit in the same cycle as new operands.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int OP_W    = 16;
    localparam int PROD_W  = 2 * OP_W;
    localparam int GUARD_W = 3;
    localparam int ACC_W   = PROD_W + GUARD_W;
    localparam int RND_POS = OP_W - 1;
    localparam int WIDE_W  = OP_W + 1;
    localparam int MUL_W   = 2 * WIDE_W;

    typedef struct packed {
        logic tc;
        logic rnd;
        logic acc;
        logic sub;
    } mode_t;

    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_PRE  = 2'd3
    } acc_op_e;

    function automatic acc_op_e pick_op(mode_t m, logic pre);
        if (pre)         return OP_PRE;
        else if (!m.acc) return OP_LOAD;
        else if (m.sub)  return OP_SUB;
        else             return OP_ADD;
    endfunction

    function automatic logic [WIDE_W-1:0] widen_op(logic [OP_W-1:0] v, logic tc);
        return {tc & v[OP_W-1], v};
    endfunction
endpackage

// File: rtl/mac_in_stage.sv
module mac_in_stage
    import mac_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] y_in,
    input  logic         x_stb,
    input  logic         y_stb,
    input  mode_t        mode_in,
    output logic [W-1:0] x_q,
    output logic [W-1:0] y_q,
    output mode_t        mode_q
);
    localparam int LANES = 2;

    logic [W-1:0] lane_d [LANES];
    logic [W-1:0] lane_q [LANES];
    logic         lane_e [LANES];

    assign lane_d[0] = x_in;
    assign lane_d[1] = y_in;
    assign lane_e[0] = x_stb;
    assign lane_e[1] = y_stb;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)            lane_q[i] <= '0;
            else if (lane_e[i]) lane_q[i] <= lane_d[i];
        end
    end

    assign x_q = lane_q[0];
    assign y_q = lane_q[1];

    always_ff @(posedge clk) begin
        if (rst)                mode_q <= '0;
        else if (x_stb | y_stb) mode_q <= mode_in;
    end
endmodule

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
#(
    parameter int W  = OP_W,
    parameter int AW = ACC_W
) (
    input  logic [W-1:0]  x_q,
    input  logic [W-1:0]  y_q,
    input  mode_t         mode_q,
    output logic [AW-1:0] prod_ext
);
    localparam int WW = W + 1;
    localparam int MW = 2 * WW;
    localparam int SX = AW - MW;

    logic signed [WW-1:0] xa, yb;
    logic signed [MW-1:0] prod_s;
    logic [AW-1:0]        ext;
    logic [AW-1:0]        rnd_add;

    always_comb begin
        xa      = $signed(widen_op(x_q, mode_q.tc));
        yb      = $signed(widen_op(y_q, mode_q.tc));
        prod_s  = xa * yb;
        ext     = {{SX{prod_s[MW-1]}}, prod_s};
        rnd_add = '0;
        rnd_add[RND_POS] = mode_q.rnd;
        prod_ext = ext + rnd_add;
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int AW = ACC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          p_stb,
    input  logic          pre_ld,
    input  logic [AW-1:0] pre_data,
    input  logic [AW-1:0] prod_ext,
    input  mode_t         mode_q,
    output logic [AW-1:0] acc_q,
    output logic [AW-1:0] acc_next
);
    acc_op_e       op;
    logic [AW-1:0] acc_d;

    always_comb begin
        op = pick_op(mode_q, 1'b0);
        unique case (op)
            OP_ADD:  acc_next = prod_ext + acc_q;
            OP_SUB:  acc_next = prod_ext - acc_q;
            default: acc_next = prod_ext;
        endcase
        acc_d = (pick_op(mode_q, pre_ld) == OP_PRE) ? pre_data : acc_next;
    end

    always_ff @(posedge clk) begin
        if (rst)        acc_q <= '0;
        else if (p_stb) acc_q <= acc_d;
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  x_in,
    input  logic [OP_W-1:0]  y_in,
    input  logic             x_stb,
    input  logic             y_stb,
    input  logic             tc_in,
    input  logic             rnd_in,
    input  logic             acc_in,
    input  logic             sub_in,
    input  logic             p_stb,
    input  logic             pre_ld,
    input  logic [ACC_W-1:0] pre_data,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] acc_next
);
    mode_t             mode_in, mode_q;
    logic [OP_W-1:0]   x_q, y_q;
    logic [ACC_W-1:0]  prod_ext;

    assign mode_in = '{tc: tc_in, rnd: rnd_in, acc: acc_in, sub: sub_in};

    mac_in_stage #(.W(OP_W)) u_in (
        .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in),
        .x_stb(x_stb), .y_stb(y_stb), .mode_in(mode_in),
        .x_q(x_q), .y_q(y_q), .mode_q(mode_q)
    );

    mac_mult #(.W(OP_W), .AW(ACC_W)) u_mul (
        .x_q(x_q), .y_q(y_q), .mode_q(mode_q), .prod_ext(prod_ext)
    );

    mac_accum #(.AW(ACC_W)) u_acc (
        .clk(clk), .rst(rst), .p_stb(p_stb), .pre_ld(pre_ld),
        .pre_data(pre_data), .prod_ext(prod_ext), .mode_q(mode_q),
        .acc_q(acc_q), .acc_next(acc_next)
    );
endmodule

// File: rtl/mac_checks.sv
module mac_checks
    import mac_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [OP_W-1:0]  x_in,
    input logic [OP_W-1:0]  y_in,
    input logic             x_stb,
    input logic             y_stb,
    input mode_t            mode_in,
    input mode_t            mode_q,
    input logic [OP_W-1:0]  x_q,
    input logic [OP_W-1:0]  y_q,
    input logic             p_stb,
    input logic             pre_ld,
    input logic [ACC_W-1:0] pre_data,
    input logic [ACC_W-1:0] prod_ext,
    input logic [ACC_W-1:0] acc_q,
    input logic [ACC_W-1:0] acc_next
);
    a_r1_x_capture: assert property (@(posedge clk) disable iff (rst)
        x_stb |=> x_q == $past(x_in));
    a_r1_y_hold: assert property (@(posedge clk) disable iff (rst)
        !y_stb |=> $stable(y_q));
    a_r2_mode_capture: assert property (@(posedge clk) disable iff (rst)
        (x_stb || y_stb) |=> mode_q == $past(mode_in));
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !(x_stb || y_stb) |=> $stable(mode_q));
    a_r3_zero_ext: assert property (@(posedge clk) disable iff (rst)
        !mode_q.tc |-> prod_ext[ACC_W-1:PROD_W] == '0);
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
        (p_stb && !pre_ld && !mode_q.acc) |=> acc_q == $past(prod_ext));
    a_r6_add: assert property (@(posedge clk) disable iff (rst)
        (p_stb && !pre_ld && mode_q.acc && !mode_q.sub)
        |=> acc_q == $past(prod_ext + acc_q));
    a_r7_sub: assert property (@(posedge clk) disable iff (rst)
        (p_stb && !pre_ld && mode_q.acc && mode_q.sub)
        |=> acc_q == $past(prod_ext - acc_q));
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !p_stb |=> $stable(acc_q));
    a_r8_commit: assert property (@(posedge clk) disable iff (rst)
        (p_stb && !pre_ld) |=> acc_q == $past(acc_next));
    a_r9_preload: assert property (@(posedge clk) disable iff (rst)
        (p_stb && pre_ld) |=> acc_q == $past(pre_data));
endmodule

bind mac_unit mac_checks u_chk (
    .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in),
    .x_stb(x_stb), .y_stb(y_stb), .mode_in(mode_in), .mode_q(mode_q),
    .x_q(x_q), .y_q(y_q), .p_stb(p_stb), .pre_ld(pre_ld),
    .pre_data(pre_data), .prod_ext(prod_ext), .acc_q(acc_q), .acc_next(acc_next)
);

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] x_in = '0, y_in = '0;
    logic        x_stb = 0, y_stb = 0, tc_in = 0, rnd_in = 0, acc_in = 0, sub_in = 0;
    logic        p_stb = 0, pre_ld = 0;
    logic [34:0] pre_data = '0;
    logic [34:0] acc_q, acc_next;

    int total = 0, bad = 0;
    logic [15:0] mx = '0, my = '0;
    logic [3:0]  mc = '0;   // {tc, rnd, acc, sub}
    logic [34:0] macc = '0;

    always #10 clk = ~clk;

    mac_unit u0 (
        .clk(clk), .rst(rst), .x_in(x_in), .y_in(y_in), .x_stb(x_stb), .y_stb(y_stb),
        .tc_in(tc_in), .rnd_in(rnd_in), .acc_in(acc_in), .sub_in(sub_in),
        .p_stb(p_stb), .pre_ld(pre_ld), .pre_data(pre_data),
        .acc_q(acc_q), .acc_next(acc_next)
    );

    function automatic logic [34:0] mprod(logic [15:0] x, logic [15:0] y, logic tc, logic rnd);
        longint p;
        if (tc) p = longint'($signed(x)) * longint'($signed(y));
        else    p = longint'({48'b0, x}) * longint'({48'b0, y});
        if (rnd) p = p + 32768;
        return p[34:0];
    endfunction

    function automatic logic [34:0] mnext();
        logic [34:0] p = mprod(mx, my, mc[3], mc[2]);
        if (!mc[1])     return p;
        else if (mc[0]) return p - macc;
        else            return p + macc;
    endfunction

    task automatic chk(string req, logic [34:0] act, logic [34:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(bit xs, bit ys, bit ps, bit pl, logic [15:0] x, logic [15:0] y,
                       logic [3:0] c, logic [34:0] pd);
        string tag;
        x_stb = xs; y_stb = ys; p_stb = ps; pre_ld = pl; x_in = x; y_in = y;
        {tc_in, rnd_in, acc_in, sub_in} = c; pre_data = pd;
        if (!ps)        tag = "R8";
        else if (pl)    tag = "R9";
        else if (!mc[1]) tag = "R5";
        else if (mc[0]) tag = "R7";
        else            tag = "R6";
        @(posedge clk);
        #1;
        if (ps) macc = pl ? pd : mnext();
        if (xs) mx = x;
        if (ys) my = y;
        if (xs || ys) mc = c;
        @(negedge clk);
        chk(tag, acc_q, macc);
        chk("R3", acc_next, mnext());
    endtask

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11", acc_q, '0);
        chk("R11", acc_next, '0);

        cyc(1, 1, 0, 0, 16'hFFFF, 16'hFFFF, 4'b0000, '0);
        chk("R3", acc_next, 35'h0FFFE0001);
        cyc(0, 0, 1, 0, 16'h0, 16'h0, 4'b0000, '0);
        chk("R5", acc_q, 35'h0FFFE0001);
        cyc(1, 1, 0, 0, 16'hFFFF, 16'hFFFF, 4'b0100, '0);
        chk("R4", acc_next, 35'h0FFFE8001);
        cyc(1, 1, 0, 0, 16'h8000, 16'h7FFF, 4'b1000, '0);
        chk("R3", acc_next, 35'h7C0008000);
        cyc(1, 1, 0, 0, 16'hFFFF, 16'hFFFF, 4'b1000, '0);
        chk("R3", acc_next, 35'h1);
        cyc(0, 0, 1, 1, 16'h0, 16'h0, 4'b1111, 35'h5);
        chk("R9", acc_q, 35'h5);
        cyc(1, 1, 0, 0, 16'h3, 16'h1, 4'b0011, '0);
        chk("R7", acc_next, 35'h7FFFFFFFE);
        cyc(0, 0, 1, 0, 16'h0, 16'h0, 4'b0000, '0);
        chk("R7", acc_q, 35'h7FFFFFFFE);
        cyc(0, 0, 1, 1, 16'h0, 16'h0, 4'b0000, 35'h7FFFFFFFF);
        cyc(1, 0, 0, 0, 16'h1, 16'h0, 4'b0010, '0);
        cyc(0, 1, 0, 0, 16'h0, 16'h1, 4'b0010, '0);
        chk("R10", acc_next, 35'h0);
        chk("R6", acc_next, macc + 35'h1);
        cyc(0, 0, 0, 0, 16'h1234, 16'h4321, 4'b1101, '0);
        chk("R1", acc_next, 35'h0);
        chk("R2", acc_next, 35'h0);
        chk("R8", acc_q, 35'h7FFFFFFFF);
        cyc(1, 0, 0, 0, 16'h2, 16'h0, 4'b0000, '0);
        chk("R2", acc_next, 35'h2);

        for (int i = 0; i < 4000; i++) begin
            logic [3:0] c = 4'($urandom);
            logic [15:0] x = 16'($urandom), y = 16'($urandom);
            if (($urandom % 8) == 0) x = 16'h8000;
            if (($urandom % 8) == 0) y = 16'hFFFF;
            cyc(($urandom % 3) != 0, ($urandom % 3) != 0, ($urandom % 2) == 0,
                ($urandom % 6) == 0, x, y, c, {3'($urandom), 32'($urandom)});
        end

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11", acc_q, '0);
        chk("R11", acc_next, '0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule